// File: doc/BRIEF.md
# UART Receive Ring-Buffer DMA Channel

This block is one receive channel that takes bytes from a UART receiver and stores them in a circular buffer in system memory. Software programs a buffer base, a buffer length and an interrupt threshold through a 32-bit register port, then sets the run bit. Each byte taken from the receive stream is written to memory at the base plus the current hardware write offset. The write pointer then advances.

Software drains the buffer by moving the read pointer forward. Both pointers hold a 16-bit offset and a wrap bit at bit 16, so a full buffer and an empty buffer are told apart. An interrupt is raised once enough unread data has built up. The channel can be halted with a handshake that lets an in-flight byte finish. A warm reset puts the channel back to idle at once.

Register map (byte offsets, 6-bit address): 0x00 STAT, 0x04 MASK, 0x08 RUN, 0x0C WRST, 0x10 HALT, 0x14 BASE_LO, 0x18 BASE_HI (bit 0 = address bit 32), 0x1C EXT, 0x20 LEN, 0x24 THR, 0x28 WPTR, 0x2C RPTR, 0x30 AVAIL (read only), 0x34 ROOM (read only). Unmapped reads return 0.

Top module: `urx_ring_dma`

## Requirements
- R1: After reset every register reads 0, and rx_ready, mem_req and irq are low.
- R2: A byte is accepted only while RUN bit 0 is 1, HALT bit 0 is 0, no byte is in flight and ROOM is nonzero. Each accepted byte produces exactly one memory write carrying that byte. mem_req and mem_data hold steady until mem_ack.
- R3: mem_addr equals the 33-bit base plus the write offset (WPTR[15:0]). Base bit 32 is BASE_HI bit 0 when EXT bit 0 is 1, and 0 otherwise.
- R4: On each acknowledged write, the WPTR offset increments. When the incremented offset equals LEN, the offset becomes 0 and bit 16 inverts.
- R5: AVAIL equals WPTR[15:0] minus RPTR[15:0], plus LEN when bit 16 of the two pointers differs. ROOM equals LEN minus AVAIL.
- R6: While ROOM is 0, rx_ready stays low and no memory write is issued, so nothing is dropped or overwritten.
- R7: STAT bit 0 is a sticky flag, set in the cycle after AVAIL ≥ THR with THR nonzero. Writing STAT with bits[1:0] = 3 clears it. Any other value leaves it unchanged. If the condition still holds, the flag sets again one cycle after the clear.
- R8: irq is high exactly when the flag is set and MASK bits[1:0] equal 3.
- R9: RPTR may be written at any time. A WPTR write is ignored while RUN is 1 or a byte is in flight.
- R10: With HALT = 1, hardware clears RUN once no byte is in flight. RUN stays 1 until the in-flight byte is acknowledged.
- R11: Writing WRST with bit 0 set clears RUN, drops any in-flight request and returns the channel to idle. The pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Channel can take a byte |
| mem_req | output | 1 | Memory byte write request |
| mem_addr | output | 33 | Memory byte address |
| mem_data | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory write accepted |
| irq | output | 1 | Threshold interrupt |

## Verification
The bench fills the buffer past the end so the write pointer wraps. A design that forgets to toggle the wrap bit would report AVAIL 0 on a full buffer and keep accepting bytes over unread data. It holds a byte valid against a full buffer: a wrong ROOM computation would show up as an extra memory write. Halt is requested while an acknowledge is held off, so a design that clears RUN too early is caught. Flag clearing is probed one cycle after the clear while the condition holds, and with a partial clear value.

// File: rtl/urx_ring_pkg.sv
package urx_ring_pkg;
  localparam int unsigned RA_W = 6;

  localparam logic [RA_W-1:0] RA_STAT    = 6'h00;
  localparam logic [RA_W-1:0] RA_MASK    = 6'h04;
  localparam logic [RA_W-1:0] RA_RUN     = 6'h08;
  localparam logic [RA_W-1:0] RA_WRST    = 6'h0C;
  localparam logic [RA_W-1:0] RA_HALT    = 6'h10;
  localparam logic [RA_W-1:0] RA_BASE_LO = 6'h14;
  localparam logic [RA_W-1:0] RA_BASE_HI = 6'h18;
  localparam logic [RA_W-1:0] RA_EXT     = 6'h1C;
  localparam logic [RA_W-1:0] RA_LEN     = 6'h20;
  localparam logic [RA_W-1:0] RA_THR     = 6'h24;
  localparam logic [RA_W-1:0] RA_WPTR    = 6'h28;
  localparam logic [RA_W-1:0] RA_RPTR    = 6'h2C;
  localparam logic [RA_W-1:0] RA_AVAIL   = 6'h30;
  localparam logic [RA_W-1:0] RA_ROOM    = 6'h34;

  typedef enum logic [0:0] {
    MV_IDLE = 1'b0,
    MV_BUSY = 1'b1
  } mv_state_e;
endpackage

// File: rtl/urx_ring_track.sv
module urx_ring_track #(
  parameter int unsigned OFF_W = 16,
  localparam int unsigned PTR_W = OFF_W + 1
) (
  input  logic [PTR_W-1:0] wptr,
  input  logic [PTR_W-1:0] rptr,
  input  logic [OFF_W-1:0] len,
  output logic [OFF_W-1:0] avail,
  output logic [OFF_W-1:0] room,
  output logic [PTR_W-1:0] wptr_adv
);
  logic [OFF_W-1:0] w_off;
  logic [OFF_W-1:0] r_off;
  logic             wrap_diff;
  logic [OFF_W-1:0] off_inc;

  always_comb begin
    w_off     = wptr[OFF_W-1:0];
    r_off     = rptr[OFF_W-1:0];
    wrap_diff = wptr[OFF_W] ^ rptr[OFF_W];
    avail     = w_off - r_off;
    if (wrap_diff) avail = avail + len;
    room      = len - avail;
    off_inc   = w_off + {{(OFF_W-1){1'b0}}, 1'b1};
    if (off_inc == len) wptr_adv = {~wptr[OFF_W], {OFF_W{1'b0}}};
    else                wptr_adv = {wptr[OFF_W], off_inc};
  end
endmodule

// File: rtl/urx_byte_mover.sv
module urx_byte_mover
  import urx_ring_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              halt,
  input  logic              warm,
  input  logic              room_nz,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack,
  output logic              adv,
  output logic              busy,
  output logic              halt_done
);
  mv_state_e         state_q, state_n;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  always_comb begin
    rx_ready  = run & ~halt & ~warm & room_nz & (state_q == MV_IDLE);
    accept    = rx_valid & rx_ready;
    busy      = (state_q == MV_BUSY);
    adv       = busy & mem_ack & ~warm;
    halt_done = run & halt & ~busy;
    mem_req   = busy;
    mem_data  = data_q;
    state_n   = state_q;
    if (warm)        state_n = MV_IDLE;
    else if (accept) state_n = MV_BUSY;
    else if (adv)    state_n = MV_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_n;
      if (accept) data_q <= rx_data;
    end
  end
endmodule

// File: rtl/urx_csr.sv
module urx_csr
  import urx_ring_pkg::*;
#(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned ADDR_W = 33,
  parameter int unsigned RDW    = 32,
  localparam int unsigned PTR_W = OFF_W + 1,
  localparam int unsigned HI_W  = ADDR_W - RDW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [RDW-1:0]    reg_wdata,
  output logic [RDW-1:0]    reg_rdata,
  input  logic              adv,
  input  logic [PTR_W-1:0]  wptr_adv,
  input  logic              busy,
  input  logic              halt_done,
  input  logic [OFF_W-1:0]  avail,
  input  logic [OFF_W-1:0]  room,
  output logic              run,
  output logic              halt,
  output logic              warm,
  output logic              flag,
  output logic [ADDR_W-1:0] base_eff,
  output logic [OFF_W-1:0]  len,
  output logic [OFF_W-1:0]  thr,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  rptr,
  output logic              irq
);
  logic              flag_q, flag_n;
  logic [1:0]        mask_q, mask_n;
  logic              run_q, run_n;
  logic              halt_q, halt_n;
  logic [RDW-1:0]    blo_q, blo_n;
  logic [HI_W-1:0]   bhi_q, bhi_n;
  logic              ext_q, ext_n;
  logic [OFF_W-1:0]  len_q, len_n;
  logic [OFF_W-1:0]  thr_q, thr_n;
  logic [PTR_W-1:0]  wptr_q, wptr_n;
  logic [PTR_W-1:0]  rptr_q, rptr_n;
  logic              cond;

  function automatic logic hit(input logic [RA_W-1:0] a);
    return reg_we && (reg_addr == a);
  endfunction

  always_comb begin
    warm   = hit(RA_WRST) && reg_wdata[0];
    cond   = (thr_q != '0) && (avail >= thr_q);
    flag_n = flag_q;
    mask_n = mask_q;
    run_n  = run_q;
    halt_n = halt_q;
    blo_n  = blo_q;
    bhi_n  = bhi_q;
    ext_n  = ext_q;
    len_n  = len_q;
    thr_n  = thr_q;
    wptr_n = wptr_q;
    rptr_n = rptr_q;

    if (hit(RA_STAT) && (reg_wdata[1:0] == 2'b11)) flag_n = 1'b0;
    else if (cond)                                 flag_n = 1'b1;

    if (hit(RA_MASK))    mask_n = reg_wdata[1:0];
    if (warm || halt_done) run_n = 1'b0;
    else if (hit(RA_RUN))  run_n = reg_wdata[0];
    if (warm)              halt_n = 1'b0;
    else if (hit(RA_HALT)) halt_n = reg_wdata[0];
    if (hit(RA_BASE_LO)) blo_n = reg_wdata;
    if (hit(RA_BASE_HI)) bhi_n = reg_wdata[HI_W-1:0];
    if (hit(RA_EXT))     ext_n = reg_wdata[0];
    if (hit(RA_LEN))     len_n = reg_wdata[OFF_W-1:0];
    if (hit(RA_THR))     thr_n = reg_wdata[OFF_W-1:0];
    if (adv)                                     wptr_n = wptr_adv;
    else if (hit(RA_WPTR) && !run_q && !busy)    wptr_n = reg_wdata[PTR_W-1:0];
    if (hit(RA_RPTR))    rptr_n = reg_wdata[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mask_q <= '0;
      run_q  <= 1'b0;
      halt_q <= 1'b0;
      blo_q  <= '0;
      bhi_q  <= '0;
      ext_q  <= 1'b0;
      len_q  <= '0;
      thr_q  <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      flag_q <= flag_n;
      mask_q <= mask_n;
      run_q  <= run_n;
      halt_q <= halt_n;
      blo_q  <= blo_n;
      bhi_q  <= bhi_n;
      ext_q  <= ext_n;
      len_q  <= len_n;
      thr_q  <= thr_n;
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
    end
  end

  always_comb begin
    run      = run_q;
    halt     = halt_q;
    flag     = flag_q;
    len      = len_q;
    thr      = thr_q;
    wptr     = wptr_q;
    rptr     = rptr_q;
    irq      = flag_q & (mask_q == 2'b11);
    base_eff = {(ext_q ? bhi_q : {HI_W{1'b0}}), blo_q};
    reg_rdata = '0;
    case (reg_addr)
      RA_STAT:    reg_rdata[0]          = flag_q;
      RA_MASK:    reg_rdata[1:0]        = mask_q;
      RA_RUN:     reg_rdata[0]          = run_q;
      RA_HALT:    reg_rdata[0]          = halt_q;
      RA_BASE_LO: reg_rdata             = blo_q;
      RA_BASE_HI: reg_rdata[HI_W-1:0]   = bhi_q;
      RA_EXT:     reg_rdata[0]          = ext_q;
      RA_LEN:     reg_rdata[OFF_W-1:0]  = len_q;
      RA_THR:     reg_rdata[OFF_W-1:0]  = thr_q;
      RA_WPTR:    reg_rdata[PTR_W-1:0]  = wptr_q;
      RA_RPTR:    reg_rdata[PTR_W-1:0]  = rptr_q;
      RA_AVAIL:   reg_rdata[OFF_W-1:0]  = avail;
      RA_ROOM:    reg_rdata[OFF_W-1:0]  = room;
      default:    reg_rdata             = '0;
    endcase
  end
endmodule

// File: rtl/urx_ring_dma.sv
module urx_ring_dma
  import urx_ring_pkg::*;
#(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned ADDR_W = 33,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RDW    = 32,
  localparam int unsigned PTR_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [RDW-1:0]    reg_wdata,
  output logic [RDW-1:0]    reg_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic              run_w, halt_w, warm_w, flag_w;
  logic              adv_w, busy_w, halt_done_w;
  logic [ADDR_W-1:0] base_w;
  logic [OFF_W-1:0]  len_w, thr_w, avail_w, room_w;
  logic [PTR_W-1:0]  wptr_w, rptr_w, wptr_adv_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  urx_csr #(.OFF_W(OFF_W), .ADDR_W(ADDR_W), .RDW(RDW)) u_csr (
    .clk(clk), .rst_n(rst_s_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .adv(adv_w), .wptr_adv(wptr_adv_w), .busy(busy_w), .halt_done(halt_done_w),
    .avail(avail_w), .room(room_w),
    .run(run_w), .halt(halt_w), .warm(warm_w), .flag(flag_w),
    .base_eff(base_w), .len(len_w), .thr(thr_w),
    .wptr(wptr_w), .rptr(rptr_w), .irq(irq)
  );

  urx_ring_track #(.OFF_W(OFF_W)) u_track (
    .wptr(wptr_w), .rptr(rptr_w), .len(len_w),
    .avail(avail_w), .room(room_w), .wptr_adv(wptr_adv_w)
  );

  urx_byte_mover #(.DATA_W(DATA_W)) u_mover (
    .clk(clk), .rst_n(rst_s_n),
    .run(run_w), .halt(halt_w), .warm(warm_w), .room_nz(room_w != '0),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .mem_req(mem_req), .mem_data(mem_data), .mem_ack(mem_ack),
    .adv(adv_w), .busy(busy_w), .halt_done(halt_done_w)
  );

  assign mem_addr = base_w + {{(ADDR_W-OFF_W){1'b0}}, wptr_w[OFF_W-1:0]};
endmodule

// File: rtl/urx_ring_dma_chk.sv
module urx_ring_dma_chk #(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = OFF_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic              run,
  input logic              halt,
  input logic              busy,
  input logic              warm,
  input logic              flag,
  input logic [OFF_W-1:0]  room,
  input logic [OFF_W-1:0]  avail,
  input logic [OFF_W-1:0]  thr,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_data,
  input logic [PTR_W-1:0]  wptr
);
  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (room != '0));

  // R2
  rdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (run && !halt && !busy));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !warm) |=> (mem_req && $stable(mem_data)));

  // R7
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past((thr != '0) && (avail >= thr)));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_ack && !warm) |=> (wptr != $past(wptr)));

  // R10
  halt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && halt && !busy) |=> !run);
endmodule

bind urx_ring_dma urx_ring_dma_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .rx_ready(rx_ready), .run(run_w), .halt(halt_w),
  .busy(busy_w), .warm(warm_w), .flag(flag_w), .room(room_w), .avail(avail_w),
  .thr(thr_w), .mem_req(mem_req), .mem_ack(mem_ack), .mem_data(mem_data),
  .wptr(wptr_w)
);

// File: tb/sim_urx_ring_dma.sv
module sim_urx_ring_dma;
  import urx_ring_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        mem_req;
  logic [32:0] mem_addr;
  logic [7:0]  mem_data;
  logic        mem_ack;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int ack_dly = 0;
  int dly_cnt;
  int wr_count;
  logic [32:0] last_addr;
  logic [7:0]  last_data;
  localparam logic [32:0] BASE = 33'h1_0000_1000;

  urx_ring_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; dly_cnt <= 0; wr_count <= 0;
      last_addr <= '0; last_data <= '0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0; dly_cnt <= 0;
    end else if (mem_req) begin
      if (dly_cnt >= ack_dly) begin
        mem_ack <= 1'b1; last_addr <= mem_addr; last_data <= mem_data;
        wr_count <= wr_count + 1;
      end else dly_cnt <= dly_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, {32'h0, v}, {32'h0, exp});
  endtask

  task automatic push_only(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    push_only(b);
    while (mem_req) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rx_ready", {63'h0, rx_ready}, 64'h0);
    chk("R1 mem_req", {63'h0, mem_req}, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);
    rdchk("R1 RUN", RA_RUN, 32'h0);
    rdchk("R1 WPTR", RA_WPTR, 32'h0);
    rdchk("R1 STAT", RA_STAT, 32'h0);
    rdchk("R1 LEN", RA_LEN, 32'h0);
  endtask

  task automatic t_fill;
    wr(RA_BASE_LO, 32'h0000_1000);
    wr(RA_BASE_HI, 32'h1);
    wr(RA_EXT, 32'h1);
    wr(RA_LEN, 32'd8);
    wr(RA_THR, 32'd6);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h55;
    repeat (3) @(negedge clk);
    chk("R2 not run ready", {63'h0, rx_ready}, 64'h0);
    chk("R2 not run no write", 64'(wr_count), 64'h0);
    rx_valid = 1'b0;
    wr(RA_RUN, 32'h1);
    for (int i = 0; i < 3; i++) begin
      send(8'hA0 + 8'(i));
      chk("R3 addr ext", {31'h0, last_addr}, {31'h0, BASE + 33'(i)});
      chk("R2 data", {56'h0, last_data}, {56'h0, 8'hA0 + 8'(i)});
    end
    chk("R2 one write per byte", 64'(wr_count), 64'd3);
    rdchk("R4 WPTR", RA_WPTR, 32'd3);
    rdchk("R5 AVAIL", RA_AVAIL, 32'd3);
    rdchk("R5 ROOM", RA_ROOM, 32'd5);
    rdchk("R7 below thr", RA_STAT, 32'h0);
  endtask

  task automatic t_thresh;
    send(8'hA3); send(8'hA4);
    rdchk("R7 five below", RA_STAT, 32'h0);
    send(8'hA5);
    @(negedge clk);
    rdchk("R7 flag set", RA_STAT, 32'h1);
    chk("R8 masked", {63'h0, irq}, 64'h0);
    wr(RA_MASK, 32'h1);
    chk("R8 partial mask", {63'h0, irq}, 64'h0);
    wr(RA_MASK, 32'h3);
    chk("R8 irq", {63'h0, irq}, 64'h1);
    wr(RA_RPTR, 32'd6);
    rdchk("R5 drained", RA_AVAIL, 32'd0);
    rdchk("R7 sticky", RA_STAT, 32'h1);
    wr(RA_STAT, 32'h1);
    rdchk("R7 partial clear", RA_STAT, 32'h1);
    wr(RA_STAT, 32'h3);
    @(negedge clk);
    rdchk("R7 cleared", RA_STAT, 32'h0);
    chk("R8 irq off", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_wrap_full;
    int c0;
    send(8'hB0); send(8'hB1);
    chk("R3 last offset", {31'h0, last_addr}, {31'h0, BASE + 33'd7});
    rdchk("R4 wrap", RA_WPTR, 32'h10000);
    rdchk("R5 wrap avail", RA_AVAIL, 32'd2);
    rdchk("R5 wrap room", RA_ROOM, 32'd6);
    for (int i = 0; i < 6; i++) send(8'hB2 + 8'(i));
    rdchk("R4 full wptr", RA_WPTR, 32'h10006);
    rdchk("R5 full avail", RA_AVAIL, 32'd8);
    rdchk("R5 full room", RA_ROOM, 32'd0);
    c0 = wr_count;
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hEE;
    repeat (5) @(negedge clk);
    chk("R6 ready low", {63'h0, rx_ready}, 64'h0);
    chk("R6 no write", 64'(wr_count), 64'(c0));
    rx_valid = 1'b0;
    wr(RA_WPTR, 32'd3);
    rdchk("R9 wptr locked", RA_WPTR, 32'h10006);
    wr(RA_RPTR, 32'h10000);
    rdchk("R9 rptr live", RA_RPTR, 32'h10000);
    rdchk("R5 avail partial", RA_AVAIL, 32'd6);
  endtask

  task automatic t_flag_reset;
    @(negedge clk);
    rdchk("R7 flag held", RA_STAT, 32'h1);
    wr(RA_STAT, 32'h3);
    rdchk("R7 cleared now", RA_STAT, 32'h0);
    @(negedge clk);
    rdchk("R7 re-set", RA_STAT, 32'h1);
    wr(RA_RPTR, 32'h10006);
    wr(RA_STAT, 32'h3);
    repeat (2) @(negedge clk);
    rdchk("R7 stays clear", RA_STAT, 32'h0);
  endtask

  task automatic t_stop;
    ack_dly = 6;
    push_only(8'hC0);
    wr(RA_HALT, 32'h1);
    chk("R10 in flight", {63'h0, mem_req}, 64'h1);
    rdchk("R10 run held", RA_RUN, 32'h1);
    while (mem_req) @(negedge clk);
    repeat (2) @(negedge clk);
    rdchk("R10 run cleared", RA_RUN, 32'h0);
    chk("R10 ready low", {63'h0, rx_ready}, 64'h0);
    chk("R10 byte landed", {56'h0, last_data}, 64'hC0);
    wr(RA_HALT, 32'h0);
    rdchk("R10 run stays", RA_RUN, 32'h0);
    rdchk("R4 wptr after stop", RA_WPTR, 32'h10007);
    ack_dly = 0;
  endtask

  task automatic t_warm;
    int c0;
    wr(RA_RUN, 32'h1);
    ack_dly = 30;
    c0 = wr_count;
    push_only(8'hD0);
    chk("R11 pending", {63'h0, mem_req}, 64'h1);
    wr(RA_WRST, 32'h1);
    rdchk("R11 run off", RA_RUN, 32'h0);
    chk("R11 req dropped", {63'h0, mem_req}, 64'h0);
    chk("R11 ready low", {63'h0, rx_ready}, 64'h0);
    chk("R11 no write", 64'(wr_count), 64'(c0));
    rdchk("R11 ptr kept", RA_WPTR, 32'h10007);
    ack_dly = 0;
  endtask

  task automatic t_noext;
    wr(RA_EXT, 32'h0);
    wr(RA_WPTR, 32'h0);
    rdchk("R9 wptr idle write", RA_WPTR, 32'h0);
    wr(RA_RPTR, 32'h0);
    wr(RA_RUN, 32'h1);
    send(8'hE0);
    chk("R3 no ext", {31'h0, last_addr}, {31'h0, 33'h0_0000_1000});
    chk("R2 data", {56'h0, last_data}, 64'hE0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_fill;
    t_thresh;
    t_wrap_full;
    t_flag_reset;
    t_stop;
    t_warm;
    t_noext;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule